// File: doc/BRIEF.md
# Sixteen-Function Flagged ALU

A purely combinational arithmetic logic unit. It takes two 16-bit operands and a 4-bit function code, and produces a 16-bit result together with three flags: carry, zero and odd parity. The block holds no state and has no clock. Its output settles from the inputs within the same cycle, so an enclosing datapath registers whatever it needs to keep.

The operations fall into three units. The bitwise unit covers passing or inverting `b` and the six two-operand logic functions. The arithmetic unit covers add, subtract, increment and decrement in 17-bit arithmetic. The shift unit moves `b` one place through rotates and logical shifts in both directions. Several functions act on `b` alone and ignore `a`. Carry is always bit 16 of the unit's 17-bit result. Zero and parity are always taken from the final 16 bits.

Top module: `alu16_core`

## Requirements
- R1: Codes 0x0, 0x1, 0x2, 0x3 and 0x4 give `b`, bitwise NOT `b`, `a` AND `b`, `a` OR `b` and `a` XOR `b`.
- R2: Code 0x5 gives `a + b` modulo 2^16, with carry set to the carry out of bit 15.
- R3: Code 0x6 gives `b + 1` modulo 2^16, with carry set only when `b` is 0xFFFF.
- R4: Code 0x7 gives `a - b` modulo 2^16, with carry set to the borrow, which is 1 exactly when `b > a` unsigned.
- R5: Code 0xE gives `b - 1` modulo 2^16, with carry set only when `b` is 0x0000.
- R6: Code 0x8 rotates `b` left by one, so that `b[15]` goes to result bit 0 and to carry. Code 0xA rotates `b` right by one, so that `b[0]` goes to result bit 15 and to carry.
- R7: Code 0x9 shifts `b` left by one with 0 into bit 0 and `b[15]` into carry. Code 0xB shifts `b` right by one with 0 into bit 15 and `b[0]` into carry.
- R8: Codes 0xC, 0xD and 0xF give `a` XNOR `b`, `a` NOR `b` and `a` NAND `b`.
- R9: Carry is 0 for codes 0x0–0x4, 0xC, 0xD and 0xF.
- R10: The zero flag is 1 exactly when all 16 result bits are 0, for every code.
- R11: The parity flag is 1 exactly when the result has an odd number of 1 bits, for every code.
- R12: For codes 0x0, 0x1, 0x6, 0x8–0xB and 0xE, the outputs do not depend on `a`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | 16 | First operand |
| b_i | input | 16 | Second operand; the sole source for single-operand codes |
| op_i | input | 4 | Function code |
| res_o | output | 16 | Result |
| carry_o | output | 1 | Bit 16 of the 17-bit result |
| zero_o | output | 1 | Result is all zeros |
| parity_o | output | 1 | Result has odd parity |

## Verification
The directed operands target the carry and borrow edges. These are 0xFFFF plus one, 0x0000 minus one, 0x8000 plus 0x8000, and a subtrahend larger than the minuend. A design that takes carry from the wrong bit, or inverts the borrow sense, flags these wrongly while its results stay correct. In the shift cases, 0x8000 and 0x0001 expose a rotate that fills with 0, a shift that refills the vacated bit, and a carry taken from the wrong end. The bench then repeats the single-operand codes with a changed `a` to catch leakage from `a`. Results of zero and results with a single set bit show whether zero or parity comes from the 17-bit value rather than the 16-bit result.

// File: rtl/alu16_pkg.sv
package alu16_pkg;
  localparam int unsigned ALU_W = 16;

  typedef enum logic [3:0] {
    OP_PASS_B = 4'h0,
    OP_NOT_B  = 4'h1,
    OP_AND    = 4'h2,
    OP_OR     = 4'h3,
    OP_XOR    = 4'h4,
    OP_ADD    = 4'h5,
    OP_INC_B  = 4'h6,
    OP_SUB    = 4'h7,
    OP_ROL_B  = 4'h8,
    OP_SHL_B  = 4'h9,
    OP_ROR_B  = 4'hA,
    OP_SHR_B  = 4'hB,
    OP_XNOR   = 4'hC,
    OP_NOR    = 4'hD,
    OP_DEC_B  = 4'hE,
    OP_NAND   = 4'hF
  } alu_op_e;

  typedef enum logic [1:0] {
    UNIT_LOGIC = 2'd0,
    UNIT_ARITH = 2'd1,
    UNIT_SHIFT = 2'd2
  } alu_unit_e;

  function automatic alu_unit_e unit_of(alu_op_e op);
    unique case (op)
      OP_ADD, OP_INC_B, OP_SUB, OP_DEC_B:     return UNIT_ARITH;
      OP_ROL_B, OP_SHL_B, OP_ROR_B, OP_SHR_B: return UNIT_SHIFT;
      default:                                return UNIT_LOGIC;
    endcase
  endfunction
endpackage

// File: rtl/alu16_logic_unit.sv
module alu16_logic_unit
  import alu16_pkg::*;
#(
  parameter int unsigned DW = ALU_W
) (
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] b_i,
  input  alu_op_e       op_i,
  output logic [DW-1:0] res_o
);
  // one bit slice per position, function chosen by the code
  for (genvar gi = 0; gi < DW; gi++) begin : g_slice
    always_comb begin
      unique case (op_i)
        OP_PASS_B: res_o[gi] = b_i[gi];
        OP_NOT_B:  res_o[gi] = ~b_i[gi];
        OP_AND:    res_o[gi] = a_i[gi] & b_i[gi];
        OP_OR:     res_o[gi] = a_i[gi] | b_i[gi];
        OP_XOR:    res_o[gi] = a_i[gi] ^ b_i[gi];
        OP_XNOR:   res_o[gi] = ~(a_i[gi] ^ b_i[gi]);
        OP_NOR:    res_o[gi] = ~(a_i[gi] | b_i[gi]);
        OP_NAND:   res_o[gi] = ~(a_i[gi] & b_i[gi]);
        default:   res_o[gi] = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/alu16_arith_unit.sv
module alu16_arith_unit
  import alu16_pkg::*;
#(
  parameter int unsigned DW = ALU_W
) (
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] b_i,
  input  alu_op_e       op_i,
  output logic [DW:0]   res_o
);
  localparam int unsigned FW = DW + 1;
  localparam logic [FW-1:0] ONE = FW'(1);

  logic [FW-1:0] a_x, b_x, lhs, rhs;
  logic          do_sub;

  assign a_x = {1'b0, a_i};
  assign b_x = {1'b0, b_i};

  // single adder; subtract via two's complement so bit DW is the borrow
  always_comb begin
    lhs    = a_x;
    rhs    = b_x;
    do_sub = 1'b0;
    unique case (op_i)
      OP_ADD:   begin lhs = a_x; rhs = b_x; end
      OP_INC_B: begin lhs = b_x; rhs = ONE; end
      OP_SUB:   begin lhs = a_x; rhs = b_x; do_sub = 1'b1; end
      OP_DEC_B: begin lhs = b_x; rhs = ONE; do_sub = 1'b1; end
      default:  begin lhs = '0;  rhs = '0;  end
    endcase
  end

  assign res_o = do_sub ? (lhs + ~rhs + ONE) : (lhs + rhs);

  always_comb begin
    // R4
    if (op_i == OP_SUB)
      sub_borrow_chk: assert (res_o[DW] == (b_i > a_i));
    // R2
    if (op_i == OP_ADD)
      add_carry_chk: assert (res_o[DW] == ((FW'(a_i) + FW'(b_i)) >> DW));
  end
endmodule

// File: rtl/alu16_shift_unit.sv
module alu16_shift_unit
  import alu16_pkg::*;
#(
  parameter int unsigned DW = ALU_W
) (
  input  logic [DW-1:0] b_i,
  input  alu_op_e       op_i,
  output logic [DW:0]   res_o
);
  logic msb, lsb;
  assign msb = b_i[DW-1];
  assign lsb = b_i[0];

  // bit DW carries the bit pushed out of the operand
  always_comb begin
    unique case (op_i)
      OP_ROL_B: res_o = {msb, b_i[DW-2:0], msb};
      OP_SHL_B: res_o = {msb, b_i[DW-2:0], 1'b0};
      OP_ROR_B: res_o = {lsb, lsb, b_i[DW-1:1]};
      OP_SHR_B: res_o = {lsb, 1'b0, b_i[DW-1:1]};
      default:  res_o = '0;
    endcase
  end

  always_comb begin
    // R7
    if (op_i == OP_SHR_B)
      shr_fill_chk: assert (res_o[DW-1] == 1'b0);
    // R6
    if (op_i == OP_ROR_B)
      ror_wrap_chk: assert (res_o[DW-1] == res_o[DW]);
  end
endmodule

// File: rtl/alu16_flag_unit.sv
module alu16_flag_unit #(
  parameter int unsigned DW = 16
) (
  input  logic [DW:0] full_i,
  output logic        carry_o,
  output logic        zero_o,
  output logic        parity_o
);
  assign carry_o  = full_i[DW];
  assign zero_o   = ~|full_i[DW-1:0];
  assign parity_o = ^full_i[DW-1:0];
endmodule

// File: rtl/alu16_core.sv
module alu16_core
  import alu16_pkg::*;
#(
  parameter int unsigned DW = ALU_W
) (
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] b_i,
  input  logic [3:0]    op_i,
  output logic [DW-1:0] res_o,
  output logic          carry_o,
  output logic          zero_o,
  output logic          parity_o
);
  alu_op_e       op;
  alu_unit_e     unit;
  logic [DW-1:0] logic_res;
  logic [DW:0]   arith_res, shift_res, full_res;

  assign op   = alu_op_e'(op_i);
  assign unit = unit_of(op);

  alu16_logic_unit #(.DW(DW)) u_logic (
    .a_i(a_i), .b_i(b_i), .op_i(op), .res_o(logic_res)
  );

  alu16_arith_unit #(.DW(DW)) u_arith (
    .a_i(a_i), .b_i(b_i), .op_i(op), .res_o(arith_res)
  );

  alu16_shift_unit #(.DW(DW)) u_shift (
    .b_i(b_i), .op_i(op), .res_o(shift_res)
  );

  always_comb begin
    unique case (unit)
      UNIT_ARITH: full_res = arith_res;
      UNIT_SHIFT: full_res = shift_res;
      default:    full_res = {1'b0, logic_res};
    endcase
  end

  assign res_o = full_res[DW-1:0];

  alu16_flag_unit #(.DW(DW)) u_flags (
    .full_i(full_res), .carry_o(carry_o), .zero_o(zero_o), .parity_o(parity_o)
  );

  always_comb begin
    // R9
    if (unit == UNIT_LOGIC)
      logic_carry_chk: assert (!carry_o);
    // R10
    zero_flag_chk: assert (zero_o == (res_o == '0));
    // R11
    parity_flag_chk: assert (parity_o == ($countones(res_o) % 2 == 1));
    // R6
    if (op == OP_ROL_B)
      rol_carry_chk: assert (carry_o == b_i[DW-1] && res_o[0] == b_i[DW-1]);
    // R7
    if (op == OP_SHL_B)
      shl_carry_chk: assert (carry_o == b_i[DW-1] && !res_o[0]);
    // R3
    if (op == OP_INC_B)
      inc_carry_chk: assert (carry_o == (b_i == '1));
    // R5
    if (op == OP_DEC_B)
      dec_borrow_chk: assert (carry_o == (b_i == '0));
  end
endmodule

// File: tb/alu16_core_tb_top.sv
module alu16_core_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic [15:0] a, b;
  logic [3:0]  op;
  logic [15:0] res;
  logic        carry, zero, parity;

  int n_vec  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  alu16_core dut_i (
    .a_i(a), .b_i(b), .op_i(op),
    .res_o(res), .carry_o(carry), .zero_o(zero), .parity_o(parity)
  );

  function automatic logic [16:0] model(logic [15:0] x, logic [15:0] y, logic [3:0] f);
    logic [16:0] xx, yy;
    xx = {1'b0, x};
    yy = {1'b0, y};
    case (f)
      4'h0: return {1'b0, y};
      4'h1: return {1'b0, ~y};
      4'h2: return {1'b0, x & y};
      4'h3: return {1'b0, x | y};
      4'h4: return {1'b0, x ^ y};
      4'h5: return xx + yy;
      4'h6: return yy + 17'd1;
      4'h7: return {(y > x), 16'(x - y)};
      4'h8: return {y[15], y[14:0], y[15]};
      4'h9: return {y[15], y[14:0], 1'b0};
      4'hA: return {y[0], y[0], y[15:1]};
      4'hB: return {y[0], 1'b0, y[15:1]};
      4'hC: return {1'b0, ~(x ^ y)};
      4'hD: return {1'b0, ~(x | y)};
      4'hE: return {(y == 16'h0), 16'(y - 16'd1)};
      default: return {1'b0, ~(x & y)};
    endcase
  endfunction

  function automatic string req_of(logic [3:0] f);
    case (f)
      4'h0, 4'h1, 4'h2, 4'h3, 4'h4: return "R1";
      4'h5: return "R2";
      4'h6: return "R3";
      4'h7: return "R4";
      4'hE: return "R5";
      4'h8, 4'hA: return "R6";
      4'h9, 4'hB: return "R7";
      default: return "R8";
    endcase
  endfunction

  function automatic bit b_only(logic [3:0] f);
    return f inside {4'h0, 4'h1, 4'h6, 4'h8, 4'h9, 4'hA, 4'hB, 4'hE};
  endfunction

  task automatic chk(string req, logic [16:0] act, logic [16:0] exp, logic [3:0] f);
    n_vec++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s op=%h a=%h b=%h actual=%h expected=%h", req, f, a, b, act, exp);
    end
  endtask

  task automatic apply(logic [15:0] x, logic [15:0] y, logic [3:0] f);
    logic [16:0] e;
    @(posedge clk);
    a = x; b = y; op = f;
    @(negedge clk);
    e = model(x, y, f);
    chk(req_of(f), {1'b0, res}, {1'b0, e[15:0]}, f);
    if (f inside {4'h0, 4'h1, 4'h2, 4'h3, 4'h4, 4'hC, 4'hD, 4'hF})
      chk("R9", {16'h0, carry}, 17'h0, f);
    else
      chk(req_of(f), {16'h0, carry}, {16'h0, e[16]}, f);
    chk("R10", {16'h0, zero}, {16'h0, (e[15:0] == 16'h0)}, f);
    chk("R11", {16'h0, parity}, {16'h0, ^e[15:0]}, f);
  endtask

  // R12: changing a alone leaves all outputs of b-only codes unchanged
  task automatic a_blind(logic [15:0] x0, logic [15:0] x1, logic [15:0] y, logic [3:0] f);
    logic [18:0] first;
    @(posedge clk);
    a = x0; b = y; op = f;
    @(negedge clk);
    first = {carry, zero, parity, res};
    @(posedge clk);
    a = x1;
    @(negedge clk);
    chk("R12", {carry, zero, parity, res[13:0]}, {first[18:16], first[13:0]}, f);
    chk("R12", {1'b0, res}, {1'b0, first[15:0]}, f);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end

  initial begin
    logic [15:0] corner [6];
    corner[0] = 16'h0000; corner[1] = 16'hFFFF; corner[2] = 16'h8000;
    corner[3] = 16'h0001; corner[4] = 16'h7FFF; corner[5] = 16'h5555;
    a = '0; b = '0; op = '0;
    void'($urandom(32'd20240611));
    @(negedge clk);
    // R1 R10 idle inputs: pass of zero gives zero result
    chk("R10", {16'h0, zero}, 17'h1, 4'h0);
    chk("R1", {1'b0, res}, 17'h0, 4'h0);

    // directed corners for every code: R1..R11
    for (int f = 0; f < 16; f++)
      for (int i = 0; i < 6; i++)
        for (int j = 0; j < 6; j++)
          apply(corner[i], corner[j], 4'(f));

    // R2 R3 R4 R5 specific edges
    apply(16'h8000, 16'h8000, 4'h5);
    apply(16'h1234, 16'hFFFF, 4'h6);
    apply(16'h0003, 16'h0004, 4'h7);
    apply(16'h0004, 16'h0004, 4'h7);
    apply(16'hABCD, 16'h0000, 4'hE);

    // R12
    for (int f = 0; f < 16; f++)
      if (b_only(4'(f))) begin
        a_blind(16'h0000, 16'hFFFF, 16'h8001, 4'(f));
        a_blind(16'h5A5A, 16'hA5A5, 16'hFFFF, 4'(f));
        a_blind(16'h1234, 16'hFEDC, 16'h0000, 4'(f));
      end

    // random mix
    for (int k = 0; k < 2000; k++)
      apply(16'($urandom), 16'($urandom), 4'($urandom));

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end
endmodule